// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside a running calendar and shifts the hour automatically at the start and the end of daylight time. Each time the seconds counter rolls over, the calendar pulses a strobe. The block then takes a snapshot of the current time and tests it against two programmed rules: a forward rule that moves the hour ahead by one and a reverse rule that moves it back by one. When a rule fires, the block issues a one-cycle hour-load request with the new hour value. The calendar copies that value into its hour counter.

Each rule holds a month and an hour with its own 12/24-hour format bit. It also holds a day criterion, which is one of two kinds. In date mode the criterion is a fixed day of the month. In week mode it is a day-of-week plus a week-of-month code. In week mode, codes 1 to 5 pick that week, code 7 picks the last seven days of the month, and 0 (or the unused code 6) never matches. A status flag records whether daylight time is in effect. A forward shift sets the flag and a reverse shift clears it. Software can force the flag to 1. Clearing the master enable clears the flag.

The control is a four-state machine:
- WATCH waits for the strobe. WATCH→CHECK happens on a strobe while the block is enabled, and the time is snapshotted on that transition.
- CHECK evaluates both rules. CHECK→FWD happens on a forward match while the flag is clear. CHECK→BACK happens on a reverse match while the flag is set. Otherwise CHECK→WATCH, which is also the path taken when the enable is low.
- FWD and BACK each issue the load request for one cycle and then return to WATCH.

Top module: `dst_adjuster`

## Requirements
- R1: After reset, dst_active is 0 and hour_load is 0. While dst_en is 0, no hour_load is issued, and dst_active is 0 from the next clock on.
- R2: Rules are evaluated only on a sec_wrap sampled high while enabled, and only if the snapshot minute is BCD 00. A resulting hour_load is high for exactly one cycle and begins two clocks after the clock edge that sampled sec_wrap.
- R3: When the forward rule matches and dst_active is 0, hour_load carries the hour plus one, and dst_active becomes 1 when the pulse ends. While dst_active is 1, a forward match is ignored.
- R4: When the reverse rule matches and dst_active is 1, hour_load carries the hour minus one, and dst_active becomes 0. While dst_active is 0, a reverse match is ignored, so the repeated hour does not fire a second time.
- R5: With the rule's by_week bit at 0, the day criterion is BCD date equality. In both modes the BCD month must be equal.
- R6: With by_week at 1, the rule day-of-week (0..6) must equal the clock's. A week code k in 1..5 then matches dates 7k-6 through 7k.
- R7: Week code 7 matches when date+7 exceeds the days in the current month. February has 29 days when the BCD year (00..99) is divisible by 4, and 28 days otherwise.
- R8: In week mode, week codes 0 and 6 never match.
- R9: The rule's mil bit (1 = 24-hour, 0 = 12-hour) must equal the clock's mil bit, and the BCD hour must be equal. In 12-hour mode the pm bit (1 = PM) must also be equal.
- R10: The hour step wraps within the format. In 24-hour mode 23→0 going forward and 0→23 going back. In 12-hour mode, 11→12 with pm toggled, 12→1 with pm kept, 12→11 with pm toggled when going back, and 1→12 with pm kept when going back.
- R11: When status_force is high while dst_en is 1, dst_active is 1 after the next clock.
- R12: The package defaults are as follows. Forward: month 04, date 01. Reverse: month 10, date 01. Both rules use date mode, day 0, week 0, and 2 AM in 12-hour format. With these defaults, 2:00 AM becomes 3 AM going forward and 1 AM going back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_en | input | 1 | Master enable |
| status_force | input | 1 | Forces dst_active to 1 |
| sec_wrap | input | 1 | Seconds-rollover strobe, one cycle |
| now_year | input | 8 | Current year, BCD 00..99 |
| now_month | input | 8 | Current month, BCD 01..12 |
| now_date | input | 8 | Current date, BCD 01..31 |
| now_dow | input | 3 | Current day of week 0..6 |
| now_hour | input | 6 | Current hour, BCD |
| now_pm | input | 1 | 1 = PM (12-hour mode) |
| now_mil | input | 1 | 1 = 24-hour format |
| now_minute | input | 8 | Current minute, BCD |
| fwd_month | input | 8 | Forward month, BCD |
| fwd_week | input | 3 | Forward week code |
| fwd_dow | input | 3 | Forward day of week |
| fwd_by_week | input | 1 | 1 = week mode, 0 = date mode |
| fwd_date | input | 8 | Forward date, BCD |
| fwd_hour | input | 6 | Forward hour, BCD |
| fwd_pm | input | 1 | Forward pm bit |
| fwd_mil | input | 1 | Forward format bit |
| rev_month | input | 8 | Reverse month, BCD |
| rev_week | input | 3 | Reverse week code |
| rev_dow | input | 3 | Reverse day of week |
| rev_by_week | input | 1 | 1 = week mode, 0 = date mode |
| rev_date | input | 8 | Reverse date, BCD |
| rev_hour | input | 6 | Reverse hour, BCD |
| rev_pm | input | 1 | Reverse pm bit |
| rev_mil | input | 1 | Reverse format bit |
| hour_load | output | 1 | One-cycle hour-load request |
| load_hour | output | 6 | New hour, BCD, valid with hour_load |
| load_pm | output | 1 | New pm bit, valid with hour_load |
| dst_active | output | 1 | Daylight time in effect |

## Verification
The assertions assume that sec_wrap pulses are at least three clocks apart. This lets each strobe finish its pass through CHECK and FWD/BACK before the next one arrives. The assertions also assume that status_force and dst_en are ordinary synchronous levels. The bench spaces every strobe five clocks apart, drives all inputs on the falling edge, and generates random times and rules from legal BCD ranges: valid dates for the month, hours within the chosen format, and days of week 0 to 6. Rule fields are copied from the drawn time and then perturbed, so that both matches and near misses occur often.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int BCD_W   = 8;
    localparam int HOUR_W  = 6;
    localparam int DOW_W   = 3;
    localparam int WEEK_W  = 3;
    localparam int BIN_W   = 7;
    localparam int WEEK_LEN    = 7;
    localparam int WEEK_LAST   = 7;
    localparam int WEEK_MAXNUM = 5;
    localparam int NUM_RULES   = 2;
    localparam int RULE_FWD    = 0;
    localparam int RULE_REV    = 1;

    typedef struct packed {
        logic [BCD_W-1:0]  month;
        logic [WEEK_W-1:0] week;
        logic [DOW_W-1:0]  dow;
        logic              by_week;
        logic [BCD_W-1:0]  date;
        logic [HOUR_W-1:0] hour;
        logic              pm;
        logic              mil;
    } dst_rule_t;

    typedef struct packed {
        logic [BCD_W-1:0]  year;
        logic [BCD_W-1:0]  month;
        logic [BCD_W-1:0]  date;
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic              pm;
        logic              mil;
        logic [BCD_W-1:0]  minute;
    } dst_time_t;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_CHECK = 2'd1,
        ST_FWD   = 2'd2,
        ST_BACK  = 2'd3
    } dst_state_t;

    // Power-up rule contents (R12)
    localparam dst_rule_t FWD_DEFAULT = '{month: 8'h04, week: 3'd0, dow: 3'd0,
                                          by_week: 1'b0, date: 8'h01,
                                          hour: 6'h02, pm: 1'b0, mil: 1'b0};
    localparam dst_rule_t REV_DEFAULT = '{month: 8'h10, week: 3'd0, dow: 3'd0,
                                          by_week: 1'b0, date: 8'h01,
                                          hour: 6'h02, pm: 1'b0, mil: 1'b0};

    function automatic logic [BIN_W-1:0] bcd_to_bin(input logic [BCD_W-1:0] b);
        return ({3'd0, b[7:4]} * 7'd10) + {3'd0, b[3:0]};
    endfunction

    function automatic logic [BCD_W-1:0] bin_to_bcd(input logic [BIN_W-1:0] v);
        logic [BIN_W-1:0] tens;
        logic [BIN_W-1:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [BIN_W-1:0] month_days(input logic [BIN_W-1:0] mon,
                                                    input logic [BIN_W-1:0] yr);
        logic [BIN_W-1:0] d;
        unique case (mon)
            7'd2:                       d = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    d = 7'd30;
            default:                    d = 7'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dst_rule_match.sv
module dst_rule_match
    import dst_pkg::*;
(
    input  dst_rule_t rule,
    input  dst_time_t now,
    output logic      hit
);

    logic [BIN_W-1:0] date_b;
    logic [BIN_W-1:0] dim;
    logic [BIN_W-1:0] wk_hi;
    logic [BIN_W-1:0] wk_lo;
    logic             week_ok;
    logic             day_ok;
    logic             hour_ok;
    logic             month_ok;

    always_comb begin
        date_b = bcd_to_bin(now.date);
        dim    = month_days(bcd_to_bin(now.month), bcd_to_bin(now.year));
        wk_hi  = {4'd0, rule.week} * 7'(WEEK_LEN);
        wk_lo  = wk_hi - 7'(WEEK_LEN - 1);
        if (rule.week == 3'(WEEK_LAST)) begin
            week_ok = ({1'b0, date_b} + 8'(WEEK_LEN)) > {1'b0, dim};
        end else if (rule.week >= 3'd1 && rule.week <= 3'(WEEK_MAXNUM)) begin
            week_ok = (date_b >= wk_lo) && (date_b <= wk_hi);
        end else begin
            week_ok = 1'b0;
        end
        if (rule.by_week) begin
            day_ok = (rule.dow == now.dow) && week_ok;
        end else begin
            day_ok = (rule.date == now.date);
        end
        hour_ok  = (rule.mil == now.mil) && (rule.hour == now.hour) &&
                   (now.mil || (rule.pm == now.pm));
        month_ok = (rule.month == now.month);
        hit      = month_ok && day_ok && hour_ok;
    end

endmodule

// File: rtl/dst_hour_step.sv
module dst_hour_step
    import dst_pkg::*;
(
    input  logic [HOUR_W-1:0] hour,
    input  logic              pm,
    input  logic              mil,
    output logic [HOUR_W-1:0] up_hour,
    output logic              up_pm,
    output logic [HOUR_W-1:0] dn_hour,
    output logic              dn_pm
);

    localparam logic [BIN_W-1:0] H24_TOP = 7'd23;
    localparam logic [BIN_W-1:0] H12_TOP = 7'd12;

    logic [BIN_W-1:0] h;
    logic [BIN_W-1:0] up_b;
    logic [BIN_W-1:0] dn_b;
    logic [BCD_W-1:0] up_bcd;
    logic [BCD_W-1:0] dn_bcd;

    always_comb begin
        h     = bcd_to_bin({2'b00, hour});
        up_pm = pm;
        dn_pm = pm;
        if (mil) begin
            up_b = (h == H24_TOP) ? 7'd0 : h + 7'd1;
            dn_b = (h == 7'd0) ? H24_TOP : h - 7'd1;
        end else begin
            if (h == H12_TOP - 7'd1) begin
                up_b  = H12_TOP;
                up_pm = ~pm;
            end else if (h == H12_TOP) begin
                up_b = 7'd1;
            end else begin
                up_b = h + 7'd1;
            end
            if (h == H12_TOP) begin
                dn_b  = H12_TOP - 7'd1;
                dn_pm = ~pm;
            end else if (h == 7'd1) begin
                dn_b = H12_TOP;
            end else begin
                dn_b = h - 7'd1;
            end
        end
        up_bcd  = bin_to_bcd(up_b);
        dn_bcd  = bin_to_bcd(dn_b);
        up_hour = up_bcd[HOUR_W-1:0];
        dn_hour = dn_bcd[HOUR_W-1:0];
    end

endmodule

// File: rtl/dst_fsm.sv
module dst_fsm
    import dst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic force_set,
    input  logic sec_wrap,
    input  logic top_of_hour,
    input  logic fwd_hit,
    input  logic rev_hit,
    output logic capture,
    output logic load,
    output logic load_up,
    output logic active
);

    dst_state_t state;
    dst_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WATCH;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WATCH: begin
                if (en && sec_wrap) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (!en)                                     state_nx = ST_WATCH;
                else if (top_of_hour && fwd_hit && !active)  state_nx = ST_FWD;
                else if (top_of_hour && rev_hit && active)   state_nx = ST_BACK;
                else                                         state_nx = ST_WATCH;
            end
            ST_FWD:  state_nx = ST_WATCH;
            ST_BACK: state_nx = ST_WATCH;
        endcase
    end

    // Outputs
    always_comb begin
        capture = 1'b0;
        load    = 1'b0;
        load_up = 1'b0;
        unique case (state)
            ST_WATCH: capture = en && sec_wrap;
            ST_CHECK: ;
            ST_FWD: begin
                load    = 1'b1;
                load_up = 1'b1;
            end
            ST_BACK: load = 1'b1;
        endcase
    end

    // Daylight-time flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (!en) begin
            active <= 1'b0;
        end else if (force_set) begin
            active <= 1'b1;
        end else if (state == ST_FWD) begin
            active <= 1'b1;
        end else if (state == ST_BACK) begin
            active <= 1'b0;
        end
    end

endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
    import dst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dst_en,
    input  logic                status_force,
    input  logic                sec_wrap,
    input  logic [BCD_W-1:0]    now_year,
    input  logic [BCD_W-1:0]    now_month,
    input  logic [BCD_W-1:0]    now_date,
    input  logic [DOW_W-1:0]    now_dow,
    input  logic [HOUR_W-1:0]   now_hour,
    input  logic                now_pm,
    input  logic                now_mil,
    input  logic [BCD_W-1:0]    now_minute,
    input  logic [BCD_W-1:0]    fwd_month,
    input  logic [WEEK_W-1:0]   fwd_week,
    input  logic [DOW_W-1:0]    fwd_dow,
    input  logic                fwd_by_week,
    input  logic [BCD_W-1:0]    fwd_date,
    input  logic [HOUR_W-1:0]   fwd_hour,
    input  logic                fwd_pm,
    input  logic                fwd_mil,
    input  logic [BCD_W-1:0]    rev_month,
    input  logic [WEEK_W-1:0]   rev_week,
    input  logic [DOW_W-1:0]    rev_dow,
    input  logic                rev_by_week,
    input  logic [BCD_W-1:0]    rev_date,
    input  logic [HOUR_W-1:0]   rev_hour,
    input  logic                rev_pm,
    input  logic                rev_mil,
    output logic                hour_load,
    output logic [HOUR_W-1:0]   load_hour,
    output logic                load_pm,
    output logic                dst_active
);

    dst_time_t              snap;
    dst_time_t              now_in;
    dst_rule_t              rules [NUM_RULES];
    logic [NUM_RULES-1:0]   hits;
    logic                   capture;
    logic                   load_up;
    logic                   top_of_hour;
    logic [HOUR_W-1:0]      up_hour;
    logic [HOUR_W-1:0]      dn_hour;
    logic                   up_pm;
    logic                   dn_pm;

    assign now_in = '{year: now_year, month: now_month, date: now_date, dow: now_dow,
                      hour: now_hour, pm: now_pm, mil: now_mil, minute: now_minute};

    assign rules[RULE_FWD] = '{month: fwd_month, week: fwd_week, dow: fwd_dow,
                               by_week: fwd_by_week, date: fwd_date,
                               hour: fwd_hour, pm: fwd_pm, mil: fwd_mil};
    assign rules[RULE_REV] = '{month: rev_month, week: rev_week, dow: rev_dow,
                               by_week: rev_by_week, date: rev_date,
                               hour: rev_hour, pm: rev_pm, mil: rev_mil};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (capture) begin
            snap <= now_in;
        end
    end

    assign top_of_hour = (snap.minute == '0);

    for (genvar gi = 0; gi < NUM_RULES; gi++) begin : g_rule
        dst_rule_match u_match (
            .rule (rules[gi]),
            .now  (snap),
            .hit  (hits[gi])
        );
    end

    dst_hour_step u_step (
        .hour    (snap.hour),
        .pm      (snap.pm),
        .mil     (snap.mil),
        .up_hour (up_hour),
        .up_pm   (up_pm),
        .dn_hour (dn_hour),
        .dn_pm   (dn_pm)
    );

    dst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (dst_en),
        .force_set   (status_force),
        .sec_wrap    (sec_wrap),
        .top_of_hour (top_of_hour),
        .fwd_hit     (hits[RULE_FWD]),
        .rev_hit     (hits[RULE_REV]),
        .capture     (capture),
        .load        (hour_load),
        .load_up     (load_up),
        .active      (dst_active)
    );

    assign load_hour = load_up ? up_hour : dn_hour;
    assign load_pm   = load_up ? up_pm : dn_pm;

endmodule

// File: rtl/dst_adjuster_chk.sv
module dst_adjuster_chk (
    input logic clk,
    input logic rst_n,
    input logic dst_en,
    input logic status_force,
    input logic sec_wrap,
    input logic hour_load,
    input logic dst_active
);

    // R1: a low enable clears the flag by the next clock
    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_en |=> !dst_active);

    // R2: load request lasts one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hour_load |=> !hour_load);

    // R2: load request comes two clocks after a strobe
    p_load_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hour_load |-> $past(sec_wrap, 2));

    // R3: flag rises only through a forward load or a force
    p_rise_by_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dst_active) && !$past(status_force)) |-> $past(hour_load));

    // R4: flag falls while enabled only through a reverse load
    p_fall_by_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dst_active) && $past(dst_en)) |-> $past(hour_load));

endmodule

bind dst_adjuster dst_adjuster_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dst_en       (dst_en),
    .status_force (status_force),
    .sec_wrap     (sec_wrap),
    .hour_load    (hour_load),
    .dst_active   (dst_active)
);

// File: tb/dst_adjuster_tb.sv
module dst_adjuster_tb;
    import dst_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dst_en = 1'b0;
    logic status_force = 1'b0;
    logic sec_wrap = 1'b0;
    logic hour_load;
    logic [5:0] load_hour;
    logic load_pm;
    logic dst_active;

    int t_yr = 24, t_mo = 1, t_dt = 1, t_dw = 0, t_hr = 12, t_pm = 0, t_mil = 0, t_mn = 0;
    int f_mo = 4, f_wk = 0, f_dw = 0, f_bw = 0, f_dt = 1, f_hr = 2, f_pm = 0, f_mil = 0;
    int r_mo = 10, r_wk = 0, r_dw = 0, r_bw = 0, r_dt = 1, r_hr = 2, r_pm = 0, r_mil = 0;

    int n_tests = 0;
    int n_fail = 0;
    int load_cnt = 0;
    int got_hr = 0;
    int got_pm = 0;
    int got_cyc = 0;
    int pcnt = 0;
    int e_hr = 0;
    int e_pm = 0;
    bit m_act = 0;

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int unbcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    dst_adjuster u_dut (
        .clk(clk), .rst_n(rst_n), .dst_en(dst_en), .status_force(status_force),
        .sec_wrap(sec_wrap),
        .now_year(bcd(t_yr)), .now_month(bcd(t_mo)), .now_date(bcd(t_dt)),
        .now_dow(3'(t_dw)), .now_hour(6'(bcd(t_hr))), .now_pm(t_pm[0]),
        .now_mil(t_mil[0]), .now_minute(bcd(t_mn)),
        .fwd_month(bcd(f_mo)), .fwd_week(3'(f_wk)), .fwd_dow(3'(f_dw)),
        .fwd_by_week(f_bw[0]), .fwd_date(bcd(f_dt)), .fwd_hour(6'(bcd(f_hr))),
        .fwd_pm(f_pm[0]), .fwd_mil(f_mil[0]),
        .rev_month(bcd(r_mo)), .rev_week(3'(r_wk)), .rev_dow(3'(r_dw)),
        .rev_by_week(r_bw[0]), .rev_date(bcd(r_dt)), .rev_hour(6'(bcd(r_hr))),
        .rev_pm(r_pm[0]), .rev_mil(r_mil[0]),
        .hour_load(hour_load), .load_hour(load_hour), .load_pm(load_pm),
        .dst_active(dst_active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) pcnt <= pcnt + 1;

    always @(negedge clk) begin
        if (hour_load) begin
            load_cnt = load_cnt + 1;
            got_hr   = unbcd({2'b00, load_hour});
            got_pm   = int'(load_pm);
            got_cyc  = pcnt;
        end
    end

    task automatic check(input string req, input bit ok, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    // Reference model
    function automatic int m_dim();
        if (t_mo == 2) return (t_yr % 4 == 0) ? 29 : 28;
        if (t_mo == 4 || t_mo == 6 || t_mo == 9 || t_mo == 11) return 30;
        return 31;
    endfunction

    function automatic bit m_hit(input int mo, input int wk, input int dw, input int bw,
                                 input int dt, input int hr, input int pm, input int mil);
        if (mo != t_mo || mil != t_mil || hr != t_hr) return 0;
        if (t_mil == 0 && pm != t_pm) return 0;
        if (bw == 0) return dt == t_dt;
        if (dw != t_dw) return 0;
        if (wk >= 1 && wk <= 5) return ((t_dt + 6) / 7) == wk;
        if (wk == 7) return t_dt > m_dim() - 7;
        return 0;
    endfunction

    task automatic m_step(input bit up);
        e_pm = t_pm;
        if (t_mil != 0) begin
            if (up) e_hr = (t_hr + 1) % 24;
            else    e_hr = (t_hr + 23) % 24;
        end else if (up) begin
            e_hr = (t_hr % 12) + 1;
            if (t_hr == 11) e_pm = 1 - t_pm;
        end else begin
            e_hr = ((t_hr + 10) % 12) + 1;
            if (t_hr == 12) e_pm = 1 - t_pm;
        end
    endtask

    task automatic fire(input string req, input bit exp_ld, input int exp_hr,
                        input int exp_pm, input bit exp_act);
        int p;
        load_cnt = 0;
        @(negedge clk);
        p = pcnt;
        sec_wrap = 1'b1;
        @(negedge clk);
        sec_wrap = 1'b0;
        repeat (3) @(negedge clk);
        check(req, load_cnt == int'(exp_ld),
              $sformatf("load count got %0d exp %0d", load_cnt, exp_ld));
        if (exp_ld && load_cnt == 1)
            check(req, got_hr == exp_hr && got_pm == exp_pm && got_cyc == p + 2,
                  $sformatf("hour/pm/delay got %0d/%0d/%0d exp %0d/%0d/2",
                            got_hr, got_pm, got_cyc - p, exp_hr, exp_pm));
        check(req, dst_active == exp_act,
              $sformatf("dst_active got %0b exp %0b", dst_active, exp_act));
    endtask

    task automatic set_time(input int yr, input int mo, input int dt, input int dw,
                            input int hr, input int pm, input int mil, input int mn);
        t_yr = yr; t_mo = mo; t_dt = dt; t_dw = dw;
        t_hr = hr; t_pm = pm; t_mil = mil; t_mn = mn;
    endtask

    task automatic set_fwd(input int mo, input int wk, input int dw, input int bw,
                           input int dt, input int hr, input int pm, input int mil);
        f_mo = mo; f_wk = wk; f_dw = dw; f_bw = bw;
        f_dt = dt; f_hr = hr; f_pm = pm; f_mil = mil;
    endtask

    task automatic set_rev(input int mo, input int wk, input int dw, input int bw,
                           input int dt, input int hr, input int pm, input int mil);
        r_mo = mo; r_wk = wk; r_dw = dw; r_bw = bw;
        r_dt = dt; r_hr = hr; r_pm = pm; r_mil = mil;
    endtask

    task automatic clear_active();
        @(negedge clk);
        dst_en = 1'b0;
        @(negedge clk);
        check("R1", dst_active == 1'b0,
              $sformatf("dst_active after disable got %0b exp 0", dst_active));
        dst_en = 1'b1;
    endtask

    task automatic force_active();
        @(negedge clk);
        status_force = 1'b1;
        @(negedge clk);
        status_force = 1'b0;
        check("R11", dst_active == 1'b1,
              $sformatf("dst_active after force got %0b exp 1", dst_active));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check("R1", hour_load == 1'b0 && dst_active == 1'b0,
              $sformatf("reset got load %0b active %0b exp 0 0", hour_load, dst_active));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: disabled block ignores a matching strobe
        set_fwd(4, 0, 0, 0, 1, 2, 0, 0);
        set_time(24, 4, 1, 3, 2, 0, 0, 0);
        fire("R1", 0, 0, 0, 0);
        dst_en = 1'b1;

        // R12: defaults from the package
        set_fwd(unbcd(FWD_DEFAULT.month), int'(FWD_DEFAULT.week), int'(FWD_DEFAULT.dow),
                int'(FWD_DEFAULT.by_week), unbcd(FWD_DEFAULT.date),
                unbcd({2'b00, FWD_DEFAULT.hour}), int'(FWD_DEFAULT.pm), int'(FWD_DEFAULT.mil));
        set_rev(unbcd(REV_DEFAULT.month), int'(REV_DEFAULT.week), int'(REV_DEFAULT.dow),
                int'(REV_DEFAULT.by_week), unbcd(REV_DEFAULT.date),
                unbcd({2'b00, REV_DEFAULT.hour}), int'(REV_DEFAULT.pm), int'(REV_DEFAULT.mil));
        check("R12", f_mo == 4 && r_mo == 10 && f_dt == 1 && r_hr == 2 && f_bw == 0,
              $sformatf("defaults got fmo %0d rmo %0d exp 4 10", f_mo, r_mo));
        set_time(24, 4, 1, 3, 2, 0, 0, 0);
        fire("R12 R3 R5", 1, 3, 0, 1);
        set_time(24, 10, 1, 2, 2, 0, 0, 0);
        fire("R12 R4 R5", 1, 1, 0, 0);
        fire("R4 repeated hour", 0, 0, 0, 0);

        // R2: minute not zero
        set_time(24, 4, 1, 3, 2, 0, 0, 30);
        fire("R2 minute", 0, 0, 0, 0);

        // R5: wrong date
        set_time(24, 4, 2, 3, 2, 0, 0, 0);
        fire("R5 date", 0, 0, 0, 0);

        // R6: week 2, Sunday, 24-hour
        set_fwd(3, 2, 0, 1, 1, 2, 0, 1);
        set_time(24, 3, 15, 0, 2, 0, 1, 0);
        fire("R6 date 15", 0, 0, 0, 0);
        set_time(24, 3, 7, 0, 2, 0, 1, 0);
        fire("R6 date 7", 0, 0, 0, 0);
        set_time(24, 3, 14, 1, 2, 0, 1, 0);
        fire("R6 dow", 0, 0, 0, 0);
        set_time(24, 3, 14, 0, 2, 0, 1, 0);
        fire("R6 date 14", 1, 3, 0, 1);
        clear_active();
        set_time(24, 3, 8, 0, 2, 0, 1, 0);
        fire("R6 date 8", 1, 3, 0, 1);

        // R3: forward ignored while active
        fire("R3 gated", 0, 0, 0, 1);
        clear_active();

        // R7: last week
        set_fwd(10, 7, 0, 1, 1, 2, 0, 1);
        set_time(23, 10, 24, 0, 2, 0, 1, 0);
        fire("R7 oct 24", 0, 0, 0, 0);
        set_time(23, 10, 25, 0, 2, 0, 1, 0);
        fire("R7 oct 25", 1, 3, 0, 1);
        clear_active();
        set_fwd(2, 7, 0, 1, 1, 2, 0, 1);
        set_time(24, 2, 22, 0, 2, 0, 1, 0);
        fire("R7 leap 22", 0, 0, 0, 0);
        set_time(24, 2, 23, 0, 2, 0, 1, 0);
        fire("R7 leap 23", 1, 3, 0, 1);
        clear_active();
        set_time(23, 2, 22, 0, 2, 0, 1, 0);
        fire("R7 common 22", 1, 3, 0, 1);
        clear_active();

        // R8: codes 0 and 6
        set_fwd(3, 0, 0, 1, 1, 2, 0, 1);
        set_time(24, 3, 1, 0, 2, 0, 1, 0);
        fire("R8 code 0", 0, 0, 0, 0);
        set_fwd(3, 6, 0, 1, 1, 2, 0, 1);
        set_time(24, 3, 29, 0, 2, 0, 1, 0);
        fire("R8 code 6", 0, 0, 0, 0);

        // R9: format and pm
        set_fwd(5, 0, 0, 0, 9, 2, 0, 0);
        set_time(24, 5, 9, 0, 2, 0, 1, 0);
        fire("R9 mil", 0, 0, 0, 0);
        set_time(24, 5, 9, 0, 2, 1, 0, 0);
        fire("R9 pm", 0, 0, 0, 0);

        // R10: wrap cases
        set_fwd(6, 0, 0, 0, 5, 23, 0, 1);
        set_time(24, 6, 5, 0, 23, 0, 1, 0);
        fire("R10 24h up", 1, 0, 0, 1);
        set_rev(6, 0, 0, 0, 6, 0, 0, 1);
        set_time(24, 6, 6, 0, 0, 0, 1, 0);
        fire("R10 24h down", 1, 23, 0, 0);
        set_fwd(6, 0, 0, 0, 7, 11, 0, 0);
        set_time(24, 6, 7, 0, 11, 0, 0, 0);
        fire("R10 12h 11am up", 1, 12, 1, 1);
        set_rev(6, 0, 0, 0, 8, 12, 0, 0);
        set_time(24, 6, 8, 0, 12, 0, 0, 0);
        fire("R10 12h 12am down", 1, 11, 1, 0);
        set_fwd(6, 0, 0, 0, 9, 12, 1, 0);
        set_time(24, 6, 9, 0, 12, 1, 0, 0);
        fire("R10 12h 12pm up", 1, 1, 1, 1);
        set_rev(6, 0, 0, 0, 10, 1, 0, 0);
        set_time(24, 6, 10, 0, 1, 0, 0, 0);
        fire("R10 12h 1am down", 1, 12, 0, 0);

        // R11: force then reverse
        force_active();
        set_rev(7, 0, 0, 0, 3, 5, 1, 0);
        set_time(24, 7, 3, 0, 5, 1, 0, 0);
        fire("R11 R4", 1, 4, 1, 0);

        // Random pass
        m_act = 0;
        for (int i = 0; i < N_RANDOM; i++) begin
            bit hf;
            bit hr;
            int tmp;
            t_yr  = int'($urandom_range(0, 99));
            t_mo  = int'($urandom_range(1, 12));
            t_dt  = int'($urandom_range(1, m_dim()));
            t_dw  = int'($urandom_range(0, 6));
            t_mil = int'($urandom_range(0, 1));
            t_hr  = (t_mil != 0) ? int'($urandom_range(0, 23)) : int'($urandom_range(1, 12));
            t_pm  = int'($urandom_range(0, 1));
            t_mn  = ($urandom_range(0, 7) == 0) ? 1 : 0;
            tmp   = (t_dt > m_dim() - 7 && $urandom_range(0, 1) == 1) ? 7 : (t_dt + 6) / 7;
            set_fwd(($urandom_range(0, 3) == 0) ? (t_mo % 12) + 1 : t_mo,
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : tmp,
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 6)) : t_dw,
                    int'($urandom_range(0, 1)),
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 28)) : t_dt,
                    t_hr, ($urandom_range(0, 3) == 0) ? 1 - t_pm : t_pm, t_mil);
            set_rev(t_mo, tmp, t_dw, int'($urandom_range(0, 1)),
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 28)) : t_dt,
                    ($urandom_range(0, 3) == 0) ? (t_hr % 12) + 1 : t_hr, t_pm,
                    ($urandom_range(0, 5) == 0) ? 1 - t_mil : t_mil);
            hf = (t_mn == 0) && m_hit(f_mo, f_wk, f_dw, f_bw, f_dt, f_hr, f_pm, f_mil) && !m_act;
            hr = (t_mn == 0) && m_hit(r_mo, r_wk, r_dw, r_bw, r_dt, r_hr, r_pm, r_mil) && m_act;
            if (hf) begin
                m_step(1'b1);
                m_act = 1;
                fire("R3 R5 R6 R7 random", 1, e_hr, e_pm, 1);
            end else if (hr) begin
                m_step(1'b0);
                m_act = 0;
                fire("R4 R9 R10 random", 1, e_hr, e_pm, 0);
            end else begin
                fire("R2 R8 random", 0, 0, 0, m_act);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule